// File: doc/BRIEF.md
# Master Clock Source Selector and Divider

This block turns three free-running clock sources (a slow clock, a main clock and a PLL output) into two derived clocks for the rest of the chip: a processor clock and a bus clock. Clock switching is modelled with clock enables. Each source arrives as a one-cycle tick that is synchronous to the system clock `clk`. Each derived clock leaves as a one-cycle tick pulse.

A single control register holds four fields:

- a source select;
- a power-of-two prescaler, whose output is the processor clock;
- a master divider (divide by 1, 2, 3 or 4), which turns the processor clock into the bus clock;
- a bit that halves the PLL before it reaches the source multiplexer.

Software writes the register over a simple one-register write strobe and reads it back combinationally. Every write clears a ready flag. The flag returns once a fixed settling wait has passed with no further writes, so that software can step the fields one at a time when it lowers the clock rate. The order for that is source first, then PLL halving, then master divider, then prescaler.

Top module: `mclk_sel_div`

## Requirements
- R1: After reset the register reads 0x0000. That value selects the slow clock, with the prescaler at 1, the master divider at 1 and PLL halving off. `ready` reads 1 and both output ticks read 0.
- R2: Bits [1:0] choose the source: 0 = slow, 1 = main, 2 = PLL. Code 3 selects no source, and neither output tick ever pulses.
- R3: Bits [6:4] hold a value p. `cpu_tick` pulses once for every 2^p ticks of the selected source.
- R4: Bits [9:8] hold a code m. `bus_tick` pulses once for every m+1 pulses of `cpu_tick`, so codes 0, 1, 2 and 3 divide by 1, 2, 3 and 4.
- R5: When bit 12 is 1, only every second PLL tick reaches the multiplexer. The bit has no effect on the slow or main sources.
- R6: `ready` reads 0 in the cycle after any write. It rises again after READY_WAIT (default 4) consecutive cycles with no write, so a write made while `ready` is low restarts the wait.
- R7: Each write replaces the whole register, so software can update one field at a time. Reading back returns the written value masked with 0x1373; every other bit reads 0.
- R8: A write clears the halving phase, the prescaler count and the divider count. Tick counts that follow a write are therefore exact from zero.
- R9: `cpu_tick` pulses in the cycle after the edge that samples the source tick completing its count. `bus_tick` pulses one cycle after the `cpu_tick` that completes its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value |
| slow_tick | input | 1 | Slow clock enable tick |
| main_tick | input | 1 | Main clock enable tick |
| pll_tick | input | 1 | PLL clock enable tick |
| cpu_tick | output | 1 | Processor clock enable tick |
| bus_tick | output | 1 | Bus clock enable tick |
| ready | output | 1 | Configuration settled |

## Verification
The write edge has the following effects:

- `ready` reads 0 in the very next cycle. It reads 1 again exactly READY_WAIT edges after the last write.
- `cpu_tick` is registered one edge after its source tick, and `bus_tick` one edge after that.
- The bench therefore drives inputs and samples outputs at falling edges and counts elapsed edges for every timing check.

For rate checks the bench sweeps every combination of source, halving, prescaler and divider. After each write it drives a 192-cycle tick pattern and then four idle cycles, which lets the two-register pipeline drain. It compares the pulse totals with floor-division results computed in the bench.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
   localparam int CTRL_W    = 16;
   localparam int SRC_W     = 2;
   localparam int PRE_W     = 3;
   localparam int MDIV_W    = 2;
   localparam int SRC_LSB   = 0;
   localparam int PRE_LSB   = 4;
   localparam int MDIV_LSB  = 8;
   localparam int HALVE_BIT = 12;

   localparam logic [CTRL_W-1:0] WR_MASK =
      CTRL_W'(((1 << SRC_W) - 1) << SRC_LSB) |
      CTRL_W'(((1 << PRE_W) - 1) << PRE_LSB) |
      CTRL_W'(((1 << MDIV_W) - 1) << MDIV_LSB) |
      CTRL_W'(1 << HALVE_BIT);

   typedef enum logic [SRC_W-1:0] {
      SRC_SLOW = 2'd0,
      SRC_MAIN = 2'd1,
      SRC_PLL  = 2'd2,
      SRC_OFF  = 2'd3
   } src_e;

   typedef struct packed {
      logic              halve;
      logic [MDIV_W-1:0] mdiv;
      logic [PRE_W-1:0]  presc;
      src_e              src;
   } cfg_t;
endpackage

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
   import mcs_pkg::*;
#(
   parameter int READY_WAIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output logic [CTRL_W-1:0] rd_data,
   output cfg_t              cfg,
   output logic              ready
);
   localparam int RCNT_W = (READY_WAIT > 1) ? $clog2(READY_WAIT) : 1;
   localparam logic [RCNT_W-1:0] RLAST = RCNT_W'(READY_WAIT - 1);

   initial begin
      assert (READY_WAIT >= 1) else $error("READY_WAIT must be at least 1");
   end

   logic [CTRL_W-1:0] reg_q;
   logic [RCNT_W-1:0] wait_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_q  <= '0;
         ready  <= 1'b1;
         wait_q <= '0;
      end else if (wr_en) begin
         reg_q  <= wr_data & WR_MASK;
         ready  <= 1'b0;
         wait_q <= '0;
      end else if (!ready) begin
         if (wait_q == RLAST) ready <= 1'b1;
         else                 wait_q <= wait_q + 1'b1;
      end
   end

   assign rd_data   = reg_q;
   assign cfg.src   = src_e'(reg_q[SRC_LSB +: SRC_W]);
   assign cfg.presc = reg_q[PRE_LSB +: PRE_W];
   assign cfg.mdiv  = reg_q[MDIV_LSB +: MDIV_W];
   assign cfg.halve = reg_q[HALVE_BIT];

   // R6: a write always drops ready in the next cycle
   p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !ready);
   // R6: ready never returns within three cycles of a write
   p_ready_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (!$past(wr_en) && !$past(wr_en, 2) && !$past(wr_en, 3)));
   // R7: unused bits read zero
   p_rd_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~WR_MASK) == '0);
endmodule

// File: rtl/mcs_src_mux.sv
module mcs_src_mux
   import mcs_pkg::*;
#(
   parameter bit HALVE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  src_e sel,
   input  logic halve,
   input  logic slow_tick,
   input  logic main_tick,
   input  logic pll_tick,
   output logic src_tick
);
   logic pll_eff;

   generate
      if (HALVE_EN) begin : g_halver
         logic phase_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr)  phase_q <= 1'b0;
            else if (pll_tick)  phase_q <= ~phase_q;
         end
         assign pll_eff = halve ? (pll_tick & phase_q) : pll_tick;

         // R5: halved PLL never yields two ticks back to back
         p_halve_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (halve && pll_eff) |=> !pll_eff);
      end else begin : g_direct
         logic unused_halve;
         assign unused_halve = halve | clr;
         assign pll_eff = pll_tick;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SRC_SLOW: src_tick = slow_tick;
         SRC_MAIN: src_tick = main_tick;
         SRC_PLL:  src_tick = pll_eff;
         default:  src_tick = 1'b0;
      endcase
   end

   // R2: the unused code passes no ticks
   p_off_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SRC_OFF) |-> !src_tick);
endmodule

// File: rtl/mcs_prescaler.sv
module mcs_prescaler #(
   parameter int PW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          in_tick,
   input  logic [PW-1:0] presc,
   output logic          out_tick
);
   localparam int CNT_W = ((1 << PW) - 1 > 0) ? (1 << PW) - 1 : 1;

   initial begin
      assert (PW >= 1 && PW <= 4) else $error("prescaler width out of range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   assign lim = ~({CNT_W{1'b1}} << presc);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q    <= '0;
         out_tick <= 1'b0;
      end else begin
         out_tick <= 1'b0;
         if (in_tick) begin
            if (cnt_q == lim) begin
               cnt_q    <= '0;
               out_tick <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R9: a processor tick follows a source tick by one cycle
   p_cpu_after_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick |-> $past(in_tick));
   // R3: with p = 0 every source tick comes out
   p_presc_unity_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_tick && !clr && presc == '0) |=> out_tick);
endmodule

// File: rtl/mcs_mdiv.sv
module mcs_mdiv #(
   parameter int MW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          in_tick,
   input  logic [MW-1:0] code,
   output logic          out_tick
);
   initial begin
      assert (MW >= 1) else $error("divider code width must be positive");
   end

   logic [MW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q    <= '0;
         out_tick <= 1'b0;
      end else begin
         out_tick <= 1'b0;
         if (in_tick) begin
            if (cnt_q == code) begin
               cnt_q    <= '0;
               out_tick <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R9: a bus tick follows a processor tick by one cycle
   p_bus_after_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick |-> $past(in_tick));
   // R4: code 0 passes every processor tick
   p_mdiv_unity_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_tick && !clr && code == '0) |=> out_tick);
   // R4: the count stays within the selected divisor
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= code);
endmodule

// File: rtl/mclk_sel_div.sv
module mclk_sel_div
   import mcs_pkg::*;
#(
   parameter int READY_WAIT = 4,
   parameter bit HALVE_EN   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wr_data,
   output logic [15:0] rd_data,
   input  logic        slow_tick,
   input  logic        main_tick,
   input  logic        pll_tick,
   output logic        cpu_tick,
   output logic        bus_tick,
   output logic        ready
);
   initial begin
      assert (CTRL_W == 16) else $error("register width mismatch");
   end

   cfg_t cfg;
   logic src_tick;

   mcs_ctrl #(.READY_WAIT(READY_WAIT)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .cfg(cfg), .ready(ready)
   );

   mcs_src_mux #(.HALVE_EN(HALVE_EN)) u_mux (
      .clk(clk), .rst_n(rst_n), .clr(wr_en), .sel(cfg.src), .halve(cfg.halve),
      .slow_tick(slow_tick), .main_tick(main_tick), .pll_tick(pll_tick),
      .src_tick(src_tick)
   );

   mcs_prescaler #(.PW(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(wr_en), .in_tick(src_tick),
      .presc(cfg.presc), .out_tick(cpu_tick)
   );

   mcs_mdiv #(.MW(MDIV_W)) u_mdiv (
      .clk(clk), .rst_n(rst_n), .clr(wr_en), .in_tick(cpu_tick),
      .code(cfg.mdiv), .out_tick(bus_tick)
   );

   // R1: after reset the outputs start quiet and ready
   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (ready && rd_data == '0 && !cpu_tick && !bus_tick));
endmodule

// File: tb/mclk_sel_div_tb.sv
module mclk_sel_div_tb;
   localparam int W = 192;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        slow_tick = 1'b0, main_tick = 1'b0, pll_tick = 1'b0;
   logic        cpu_tick, bus_tick, ready;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mclk_sel_div u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .slow_tick(slow_tick), .main_tick(main_tick),
      .pll_tick(pll_tick), .cpu_tick(cpu_tick), .bus_tick(bus_tick),
      .ready(ready)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [15:0] d);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic measure(output int nc, output int nb);
      nc = 0;
      nb = 0;
      for (int c = 0; c < W + 4; c++) begin
         if (cpu_tick) nc++;
         if (bus_tick) nb++;
         slow_tick = (c < W) && (c % 8 == 0);
         main_tick = (c < W) && (c % 2 == 0);
         pll_tick  = (c < W);
         @(negedge clk);
      end
   endtask

   function automatic logic [15:0] cfg_word(int s, int h, int p, int m);
      return 16'(s) | 16'(p << 4) | 16'(m << 8) | 16'(h << 12);
   endfunction

   function automatic int src_count(int s, int h);
      case (s)
         0: return W / 8;
         1: return W / 2;
         2: return (h != 0) ? W / 2 : W;
         default: return 0;
      endcase
   endfunction

   initial begin
      int nc, nb, exp_c;
      logic [15:0] cur;
      wait_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rd_data", int'(rd_data), 0);
      chk("R1 ready", int'(ready), 1);
      chk("R1 cpu_tick", int'(cpu_tick), 0);
      chk("R1 bus_tick", int'(bus_tick), 0);
      measure(nc, nb);
      chk("R1 slow cpu count", nc, W / 8);
      chk("R1 slow bus count", nb, W / 8);

      // R7 readback mask
      do_write(16'hFFFF);
      chk("R7 readback mask", int'(rd_data), 16'h1373);

      // R6 ready timing and restart
      wait_cyc(6);
      chk("R6 ready idle", int'(ready), 1);
      do_write(16'h0001);
      chk("R6 ready low after write", int'(ready), 0);
      wait_cyc(3);
      chk("R6 ready low at 3", int'(ready), 0);
      wait_cyc(1);
      chk("R6 ready high at 4", int'(ready), 1);
      do_write(16'h0002);
      wait_cyc(2);
      do_write(16'h0001);
      wait_cyc(1);
      chk("R6 restart keeps low", int'(ready), 0);
      wait_cyc(2);
      chk("R6 restart low at 3", int'(ready), 0);
      wait_cyc(1);
      chk("R6 restart high at 4", int'(ready), 1);

      // R9 latency, PLL direct, p=0, m=0
      do_write(cfg_word(2, 0, 0, 0));
      wait_cyc(4);
      pll_tick = 1'b1;
      @(negedge clk);
      pll_tick = 1'b0;
      chk("R9 cpu one cycle later", int'(cpu_tick), 1);
      chk("R9 bus not yet", int'(bus_tick), 0);
      @(negedge clk);
      chk("R9 cpu single pulse", int'(cpu_tick), 0);
      chk("R9 bus two cycles later", int'(bus_tick), 1);

      // R2 R3 R4 R5 R8 sweep
      for (int s = 0; s < 4; s++)
         for (int h = 0; h < 2; h++)
            for (int p = 0; p < 8; p++)
               for (int m = 0; m < 4; m++) begin
                  do_write(cfg_word(s, h, p, m));
                  measure(nc, nb);
                  exp_c = src_count(s, h) >> p;
                  chk($sformatf("R3 R2 R5 R8 cpu s=%0d h=%0d p=%0d m=%0d", s, h, p, m),
                      nc, exp_c);
                  chk($sformatf("R4 R8 bus s=%0d h=%0d p=%0d m=%0d", s, h, p, m),
                      nb, exp_c / (m + 1));
               end

      // R7 stepwise slow-down, one field per write
      cur = cfg_word(1, 1, 5, 3);
      do_write(cur);
      wait_cyc(4);
      cur[1:0] = 2'd0;
      do_write(cur);
      chk("R7 source step readback", int'(rd_data), int'(cfg_word(0, 1, 5, 3)));
      wait_cyc(4);
      cur[12] = 1'b0;
      do_write(cur);
      chk("R7 halve step readback", int'(rd_data), int'(cfg_word(0, 0, 5, 3)));
      wait_cyc(4);
      cur[9:8] = 2'd1;
      do_write(cur);
      chk("R7 mdiv step readback", int'(rd_data), int'(cfg_word(0, 0, 5, 1)));
      wait_cyc(4);
      cur[6:4] = 3'd2;
      do_write(cur);
      chk("R7 presc step readback", int'(rd_data), int'(cfg_word(0, 0, 2, 1)));
      measure(nc, nb);
      chk("R7 final cpu count", nc, (W / 8) >> 2);
      chk("R7 final bus count", nb, ((W / 8) >> 2) / 2);
      chk("R7 ready after steps", int'(ready), 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule